// File: doc/BRIEF.md
# Processor Exception Control Unit

This unit decides when a small in-order processor leaves its normal instruction flow for a handler, and how it comes back. The core offers a vector of synchronous trap requests for the instruction at the exception point, together with that instruction's PC. Six hardware interrupt lines and two software-settable interrupt bits form a group of asynchronous sources, and each source has its own mask bit. When an exception is accepted, the unit records a cause code and saves the PC. It pushes a three-deep stack of mode/enable pairs, which places the core in kernel mode with interrupts off, and it redirects fetch to the fixed handler entry for one cycle.

Software reads and writes three control registers through a coprocessor index: status at 12, cause at 13 and the saved exception PC at 14. A return request pops the mode/enable stack and redirects fetch to the saved PC. The controller is a three-state machine. RUN is the normal state. ENTER lasts one cycle and drives the handler address after an exception is accepted. RETURN lasts one cycle and drives the saved PC after a return. The transitions are RUN→ENTER on an accepted exception, RUN→RETURN on a return request with no exception, and ENTER→RUN and RETURN→RUN unconditionally.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, status (index 12), cause (index 13, with no interrupt line high) and exception PC (index 14) read 0, `redirect_valid` is 0 and `kernel_mode` is 1.
- R2: In RUN, a nonzero `trap_req` sampled at a clock edge makes `redirect_valid` 1 with `redirect_pc` = 0x8000_0080 in the following cycle, sets `kernel_mode`, and loads the exception PC with `cur_pc`.
- R3: The cause code occupies cause bits [5:2]. Trap bit 0 is an illegal instruction (code 10), bit 1 is an unaligned load (code 4), bit 2 is an arithmetic overflow (code 12) and bit 3 is a system call (code 8). When several trap bits are set, the lowest-numbered one sets the code.
- R4: An interrupt is accepted only when status bit 0 (enable) is 1 and at least one pending source has its mask bit set. Pending source i appears at cause bit 8+i and is masked by status bit 8+i. An accepted interrupt records code 0.
- R5: The status register holds masks in bits [15:8] and the mode/enable stack in bits [5:0]. Each pair is {user, enable}, with the current pair at [1:0], the previous pair at [3:2] and the oldest at [5:4]. Entry shifts the stack up by one pair and loads 00 into the current pair. `kernel_mode` is the inverse of bit 1.
- R6: In RUN, a return request with no exception accepted gives `redirect_valid` 1 with `redirect_pc` equal to the exception PC in the following cycle. It also copies the previous pair into the current pair and the oldest pair into the previous pair, and the oldest pair keeps its value.
- R7: Cause bits [15:10] show the live `irq_lines`, and bits [9:8] are the software interrupt bits, written by a move to index 13. A move to cause leaves every other cause bit unchanged.
- R8: A move to index 14 replaces the whole exception PC, and a later return redirects to the written value.
- R9: An accepted exception takes precedence over a return request and over a register write issued in the same cycle, and the write is discarded. A trap takes precedence over interrupts.
- R10: `redirect_valid` lasts exactly one cycle. Requests presented during ENTER or RETURN are ignored.
- R11: Reads of any index other than 12, 13 and 14 return 0. A move to status writes only bits [15:8] and [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 4 | Synchronous trap requests of the current instruction |
| irq_lines | input | 6 | Hardware interrupt lines, synchronous to clk |
| cur_pc | input | 32 | PC of the instruction at the exception point |
| eret_req | input | 1 | Return-from-exception request |
| cp_wr | input | 1 | Move-to strobe |
| cp_idx | input | 5 | Coprocessor register index for read and write |
| cp_wdata | input | 32 | Move-to data |
| cp_rdata | output | 32 | Move-from data for `cp_idx` (combinational) |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |
| kernel_mode | output | 1 | Current mode is kernel |

## Verification
Single trap bits and combined trap vectors show whether the priority among the trap codes is honoured. Interrupt lines are applied with the enable bit off, then with the mask off, then with both on, which separates the gating by the enable bit from the gating by the mask. Traps, interrupts, returns and writes are issued in the same cycle to test precedence, and requests issued during the one-cycle redirect states check that they are ignored. A seeded random mix of traps, line activity, returns and register writes then exercises the stack push and pop sequences and the read paths against a model built from the requirements.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NTRAP  = 4;
    localparam int CODE_W = 4;

    localparam logic [4:0] IDX_STATUS = 5'd12;
    localparam logic [4:0] IDX_CAUSE  = 5'd13;
    localparam logic [4:0] IDX_EPC    = 5'd14;

    localparam logic [CODE_W-1:0] CODE_INTR     = 4'd0;
    localparam logic [CODE_W-1:0] CODE_LD_ALIGN = 4'd4;
    localparam logic [CODE_W-1:0] CODE_SYSCALL  = 4'd8;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL  = 4'd10;
    localparam logic [CODE_W-1:0] CODE_OVERFLOW = 4'd12;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ENTER,
        ST_RETURN
    } exc_state_e;

    // trap_req bit position -> cause code
    function automatic logic [CODE_W-1:0] trap_code(input int idx);
        case (idx)
            0:       trap_code = CODE_ILLEGAL;
            1:       trap_code = CODE_LD_ALIGN;
            2:       trap_code = CODE_OVERFLOW;
            default: trap_code = CODE_SYSCALL;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic [NTRAP-1:0]  trap_req,
    input  logic [NSRC-1:0]   pending,
    input  logic [NSRC-1:0]   mask,
    input  logic              irq_en,
    output logic              take,
    output logic [CODE_W-1:0] code
);

    logic trap_hit;
    logic irq_hit;

    always_comb begin
        trap_hit = |trap_req;
        irq_hit  = irq_en & (|(pending & mask));
        code     = CODE_INTR;
        // scan downward so the lowest set trap bit decides
        for (int i = NTRAP - 1; i >= 0; i--) begin
            if (trap_req[i]) begin
                code = trap_code(i);
            end
        end
        take = trap_hit | irq_hit;
    end

endmodule

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
    parameter int DEPTH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic               load,
    input  logic [2*DEPTH-1:0] load_val,
    output logic [2*DEPTH-1:0] stack_q
);

    localparam int W = 2 * DEPTH;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stack_q <= '0;
        end else if (push) begin
            stack_q <= {stack_q[W-3:0], 2'b00};
        end else if (pop) begin
            stack_q <= {stack_q[W-1 -: 2], stack_q[W-1:2]};
        end else if (load) begin
            stack_q <= load_val;
        end
    end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int               XLEN        = 32,
    parameter int               HW_N        = 6,
    parameter int               SW_N        = 2,
    parameter int               STACK_DEPTH = 3,
    parameter logic [XLEN-1:0]  HANDLER     = 32'h8000_0080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRAP-1:0] trap_req,
    input  logic [HW_N-1:0]  irq_lines,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             eret_req,
    input  logic             cp_wr,
    input  logic [4:0]       cp_idx,
    input  logic [XLEN-1:0]  cp_wdata,
    output logic [XLEN-1:0]  cp_rdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             kernel_mode
);

    localparam int NSRC     = HW_N + SW_N;
    localparam int SRC_LSB  = 8;
    localparam int CODE_LSB = 2;
    localparam int STK_W    = 2 * STACK_DEPTH;

    exc_state_e state_q, state_d;

    logic [NSRC-1:0]   mask_q;
    logic [SW_N-1:0]   sw_q;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   epc_q;
    logic [STK_W-1:0]  stack_q;
    logic [NSRC-1:0]   pending;
    logic [CODE_W-1:0] sel_code;
    logic              take_raw;
    logic              ie;
    logic              in_run;
    logic              do_take;
    logic              do_eret;
    logic              do_wr;

    assign pending = {irq_lines, sw_q};
    assign ie      = stack_q[0];
    assign in_run  = (state_q == ST_RUN);
    assign do_take = in_run & take_raw;
    assign do_eret = in_run & ~take_raw & eret_req;
    assign do_wr   = in_run & ~take_raw & ~eret_req & cp_wr;

    exc_prio #(.NSRC(NSRC)) i_prio (
        .trap_req (trap_req),
        .pending  (pending),
        .mask     (mask_q),
        .irq_en   (ie),
        .take     (take_raw),
        .code     (sel_code)
    );

    exc_mode_stack #(.DEPTH(STACK_DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_take),
        .pop      (do_eret),
        .load     (do_wr && cp_idx == IDX_STATUS),
        .load_val (cp_wdata[STK_W-1:0]),
        .stack_q  (stack_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (take_raw) begin
                    state_d = ST_ENTER;
                end else if (eret_req) begin
                    state_d = ST_RETURN;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_ENTER:  state_d = ST_RUN;
            ST_RETURN: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // outputs per state
    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        unique case (state_q)
            ST_RUN: begin
                redirect_valid = 1'b0;
                redirect_pc    = '0;
            end
            ST_ENTER: begin
                redirect_valid = 1'b1;
                redirect_pc    = HANDLER;
            end
            ST_RETURN: begin
                redirect_valid = 1'b1;
                redirect_pc    = epc_q;
            end
            default: begin
                redirect_valid = 1'b0;
                redirect_pc    = '0;
            end
        endcase
    end

    assign kernel_mode = ~stack_q[1];

    // cause / epc / mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            sw_q   <= '0;
            code_q <= '0;
            epc_q  <= '0;
        end else if (do_take) begin
            code_q <= sel_code;
            epc_q  <= cur_pc;
        end else if (do_wr) begin
            if (cp_idx == IDX_STATUS) begin
                mask_q <= cp_wdata[SRC_LSB +: NSRC];
            end
            if (cp_idx == IDX_CAUSE) begin
                sw_q <= cp_wdata[SRC_LSB +: SW_N];
            end
            if (cp_idx == IDX_EPC) begin
                epc_q <= cp_wdata;
            end
        end
    end

    // move-from read port
    always_comb begin
        cp_rdata = '0;
        if (cp_idx == IDX_STATUS) begin
            cp_rdata[SRC_LSB +: NSRC] = mask_q;
            cp_rdata[STK_W-1:0]       = stack_q;
        end else if (cp_idx == IDX_CAUSE) begin
            cp_rdata[SRC_LSB +: NSRC]   = pending;
            cp_rdata[CODE_LSB +: CODE_W] = code_q;
        end else if (cp_idx == IDX_EPC) begin
            cp_rdata = epc_q;
        end
    end

endmodule

// File: rtl/exc_ctrl_checker.sv
module exc_ctrl_checker
    import exc_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] HANDLER = 32'h8000_0080
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NTRAP-1:0] trap_req,
    input logic             eret_req,
    input logic             cp_wr,
    input logic [4:0]       cp_idx,
    input logic [XLEN-1:0]  cur_pc,
    input logic             redirect_valid,
    input logic [XLEN-1:0]  redirect_pc,
    input logic             kernel_mode,
    input logic             take,
    input logic             ie,
    input logic [XLEN-1:0]  epc
);

    a_r2_handler_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && |trap_req) |=> (redirect_valid && redirect_pc == HANDLER && kernel_mode));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    a_r6_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && eret_req && !take) |=> (redirect_valid && redirect_pc == epc));

    a_r4_disabled_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && trap_req == '0 && !eret_req && !ie) |=> !redirect_valid);

    a_r9_trap_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && |trap_req && cp_wr && cp_idx == IDX_EPC) |=> (epc == $past(cur_pc)));

endmodule

bind exc_ctrl_unit exc_ctrl_checker #(.XLEN(XLEN), .HANDLER(HANDLER)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_req       (trap_req),
    .eret_req       (eret_req),
    .cp_wr          (cp_wr),
    .cp_idx         (cp_idx),
    .cur_pc         (cur_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .kernel_mode    (kernel_mode),
    .take           (take_raw),
    .ie             (ie),
    .epc            (epc_q)
);

// File: tb/test_exc_ctrl_unit.sv
module test_exc_ctrl_unit;

    localparam logic [31:0] HVEC = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  trap_req = '0;
    logic [5:0]  irq_lines = '0;
    logic [31:0] cur_pc = '0;
    logic        eret_req = 1'b0;
    logic        cp_wr = 1'b0;
    logic [4:0]  cp_idx = '0;
    logic [31:0] cp_wdata = '0;
    logic [31:0] cp_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        kernel_mode;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model of architectural state
    int          m_state = 0;   // 0 run, 1 enter, 2 return
    logic [5:0]  m_stack = '0;
    logic [7:0]  m_mask = '0;
    logic [1:0]  m_sw = '0;
    logic [3:0]  m_code = '0;
    logic [31:0] m_epc = '0;

    always #5 clk = ~clk;

    exc_ctrl_unit i_exc_ctrl_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .trap_req       (trap_req),
        .irq_lines      (irq_lines),
        .cur_pc         (cur_pc),
        .eret_req       (eret_req),
        .cp_wr          (cp_wr),
        .cp_idx         (cp_idx),
        .cp_wdata       (cp_wdata),
        .cp_rdata       (cp_rdata),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .kernel_mode    (kernel_mode)
    );

    function automatic logic [31:0] exp_read(input logic [4:0] idx, input logic [5:0] irq);
        case (idx)
            5'd12:   exp_read = {16'b0, m_mask, 2'b0, m_stack};
            5'd13:   exp_read = {16'b0, irq, m_sw, 2'b0, m_code, 2'b0};
            5'd14:   exp_read = m_epc;
            default: exp_read = 32'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_code(input logic [3:0] tr);
        if (tr[0])      exp_code = 4'd10;
        else if (tr[1]) exp_code = 4'd4;
        else if (tr[2]) exp_code = 4'd12;
        else if (tr[3]) exp_code = 4'd8;
        else            exp_code = 4'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update(input logic [3:0] tr, input logic [5:0] irq, input logic er,
                                input logic wr, input logic [4:0] idx, input logic [31:0] wd,
                                input logic [31:0] pc);
        logic irq_take;
        if (m_state != 0) begin
            m_state = 0;
        end else begin
            irq_take = m_stack[0] & (|({irq, m_sw} & m_mask));
            if (|tr || irq_take) begin
                m_code  = exp_code(tr);
                m_epc   = pc;
                m_stack = {m_stack[3:0], 2'b00};
                m_state = 1;
            end else if (er) begin
                m_stack = {m_stack[5:4], m_stack[5:2]};
                m_state = 2;
            end else if (wr) begin
                if (idx == 5'd12) begin
                    m_mask  = wd[15:8];
                    m_stack = wd[5:0];
                end else if (idx == 5'd13) begin
                    m_sw = wd[9:8];
                end else if (idx == 5'd14) begin
                    m_epc = wd;
                end
            end
        end
    endtask

    // one clock: drive at negedge, check read port, clock, check redirect
    task automatic step(input logic [3:0] tr, input logic [5:0] irq, input logic er,
                        input logic wr, input logic [4:0] idx, input logic [31:0] wd,
                        input logic [31:0] pc);
        string rtag;
        string dtag;
        trap_req = tr; irq_lines = irq; eret_req = er;
        cp_wr = wr; cp_idx = idx; cp_wdata = wd; cur_pc = pc;
        #1;
        rtag = (idx == 5'd12) ? "R5" : (idx == 5'd13) ? "R7" : (idx == 5'd14) ? "R8" : "R11";
        chk(rtag, cp_rdata, exp_read(idx, irq));
        @(posedge clk);
        model_update(tr, irq, er, wr, idx, wd, pc);
        @(negedge clk);
        dtag = (m_state == 1) ? "R2" : (m_state == 2) ? "R6" : "R10";
        chk(dtag, {31'b0, redirect_valid}, {31'b0, m_state != 0});
        if (m_state == 1) chk("R2", redirect_pc, HVEC);
        if (m_state == 2) chk("R6", redirect_pc, m_epc);
        chk("R5", {31'b0, kernel_mode}, {31'b0, ~m_stack[1]});
    endtask

    task automatic idle();
        step(4'h0, 6'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0);
    endtask

    task automatic wreg(input logic [4:0] idx, input logic [31:0] wd);
        step(4'h0, 6'h0, 1'b0, 1'b1, idx, wd, 32'h0);
    endtask

    task automatic peek(input logic [4:0] idx, input logic [5:0] irq, input logic [31:0] exp, input string tag);
        trap_req = '0; irq_lines = irq; eret_req = 1'b0; cp_wr = 1'b0;
        cp_idx = idx; cp_wdata = '0;
        #1;
        chk(tag, cp_rdata, exp);
        irq_lines = '0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1221));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(5'd12, 6'h0, 32'h0, "R1");
        peek(5'd13, 6'h0, 32'h0, "R1");
        peek(5'd14, 6'h0, 32'h0, "R1");
        chk("R1", {31'b0, redirect_valid}, 32'h0);
        chk("R1", {31'b0, kernel_mode}, 32'h1);

        // R2 / R3 / R5 system call from user mode
        wreg(5'd12, 32'h0000_FF03);
        step(4'b1000, 6'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0000_0400);
        chk("R2", redirect_pc, HVEC);
        peek(5'd13, 6'h0, 32'h0000_0020, "R3");
        peek(5'd12, 6'h0, 32'h0000_FF0C, "R5");
        peek(5'd14, 6'h0, 32'h0000_0400, "R2");
        idle();
        chk("R10", {31'b0, redirect_valid}, 32'h0);

        // R6 return pops the stack
        step(4'h0, 6'h0, 1'b1, 1'b0, 5'd0, 32'h0, 32'h0);
        chk("R6", redirect_pc, 32'h0000_0400);
        peek(5'd12, 6'h0, 32'h0000_FF03, "R6");
        chk("R6", {31'b0, kernel_mode}, 32'h0);
        idle();

        // R4 gating by enable and mask
        wreg(5'd12, 32'h0000_0001);
        step(4'h0, 6'h01, 1'b0, 1'b0, 5'd0, 32'h0, 32'h10);
        chk("R4", {31'b0, redirect_valid}, 32'h0);
        wreg(5'd12, 32'h0000_0400);
        step(4'h0, 6'h01, 1'b0, 1'b0, 5'd0, 32'h0, 32'h14);
        chk("R4", {31'b0, redirect_valid}, 32'h0);
        wreg(5'd12, 32'h0000_0401);
        step(4'h0, 6'h01, 1'b0, 1'b0, 5'd0, 32'h0, 32'h18);
        chk("R4", {31'b0, redirect_valid}, 32'h1);
        peek(5'd13, 6'h0, 32'h0, "R4");
        peek(5'd14, 6'h0, 32'h18, "R4");
        idle();

        // R7 software bits writable, others not
        wreg(5'd13, 32'hFFFF_FFFF);
        peek(5'd13, 6'h0, 32'h0000_0300, "R7");
        peek(5'd13, 6'h3F, 32'h0000_FF00, "R7");
        wreg(5'd13, 32'h0);

        // R8 writable exception PC
        wreg(5'd14, 32'h0000_1234);
        step(4'h0, 6'h0, 1'b1, 1'b0, 5'd0, 32'h0, 32'h0);
        chk("R8", redirect_pc, 32'h0000_1234);
        idle();

        // R9 precedence
        wreg(5'd12, 32'h0000_FF01);
        step(4'b1010, 6'h3F, 1'b1, 1'b1, 5'd14, 32'h0000_DEAD, 32'h0000_0500);
        chk("R9", redirect_pc, HVEC);
        peek(5'd13, 6'h0, 32'h0000_0010, "R9");
        peek(5'd14, 6'h0, 32'h0000_0500, "R9");

        // R10 requests during ENTER ignored
        step(4'b0001, 6'h0, 1'b0, 1'b1, 5'd14, 32'h0000_0BAD, 32'h0000_0600);
        chk("R10", {31'b0, redirect_valid}, 32'h0);
        peek(5'd14, 6'h0, 32'h0000_0500, "R10");
        peek(5'd13, 6'h0, 32'h0000_0010, "R10");

        // R3 trap priority
        step(4'b1100, 6'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h700);
        idle();
        peek(5'd13, 6'h0, 32'h0000_0030, "R3");
        step(4'b1111, 6'h0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h704);
        idle();
        peek(5'd13, 6'h0, 32'h0000_0028, "R3");

        // R11 unmapped index and status write width
        peek(5'd5, 6'h0, 32'h0, "R11");
        wreg(5'd12, 32'hFFFF_FFFF);
        peek(5'd12, 6'h0, 32'h0000_FF3F, "R11");
        wreg(5'd12, 32'h0);

        // seeded random mix
        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  tr;
            logic [5:0]  irq;
            logic [4:0]  idx;
            tr  = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'h0;
            irq = ($urandom % 4 == 0) ? 6'($urandom % 64) : 6'h0;
            case ($urandom % 4)
                0:       idx = 5'd12;
                1:       idx = 5'd13;
                2:       idx = 5'd14;
                default: idx = 5'd3;
            endcase
            step(tr, irq, ($urandom % 8 == 0), ($urandom % 4 == 0), idx,
                 $urandom, $urandom & 32'hFFFF_FFFC);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule